// File: doc/BRIEF.md
# Segmented Page Table Walker

This block resolves a virtual address into a physical address after a TLB miss, in a system where each of three segments (code, heap and stack) owns its own linear page table. The two most significant address bits choose the segment. Each segment has a table base and a table length in entries, and both arrive as input ports. The walker splits the address into segment, virtual page number and page offset. It rejects a segment number that maps to no segment, and it rejects a page number past the end of the table. In both cases no memory access takes place. Otherwise it forms the entry address and performs one read on a request/acknowledge memory port.

The returned entry is checked for validity and presence. On success the walker reports the physical address, made of the entry's frame number followed by the untouched page offset, and it also returns the whole entry so that the TLB can be filled. On failure it reports a fault code. It handles one translation at a time. `busy` covers the whole walk, and a one-cycle `done` pulse marks the cycle in which the result is valid.

Top module: `seg_pt_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done` and `mem_req` are low.
- R2: Segment field `va[31:30]` selects the table: 2'b01 uses code base/bounds, 2'b10 uses heap, 2'b11 uses stack. The value 2'b00 ends the walk with fault code 1 and no memory request.
- R3: If the page number `va[29:12]` is greater than or equal to the selected segment's bounds, the walk ends with fault code 2 and no memory request. A page number of bounds-1 is fetched.
- R4: The entry is read at address `base + vpn*4`, taken modulo 2^32.
- R5: `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_ack` high, and then drops. Each translation makes at most one request.
- R6: Entry layout: bit 0 valid, bit 1 present, bit 2 dirty, bit 3 read, bit 4 write, bit 5 execute, bits 31:12 frame number. Valid=0 gives fault code 3. Valid=1 with present=0 gives fault code 4. On either fault `pa` is 0 and `res_pte` carries the entry.
- R7: A valid, present entry gives fault code 0, `pa = {entry[31:12], va[11:0]}` and `res_pte` equal to the entry.
- R8: `done` is high for exactly one cycle. A segment or bounds fault shows `done` two cycles after `start` is sampled. A fetched walk shows `done` one cycle after the acknowledge is sampled. On a segment or bounds fault, `pa` and `res_pte` are 0.
- R9: `start` is ignored while `busy` is high. It neither changes the result in flight nor queues a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk for `va` (sampled when idle) |
| va | input | 32 | Virtual address to translate |
| code_base | input | 32 | Physical address of the code page table |
| code_bounds | input | 19 | Code table length in entries |
| heap_base | input | 32 | Physical address of the heap page table |
| heap_bounds | input | 19 | Heap table length in entries |
| stack_base | input | 32 | Physical address of the stack page table |
| stack_bounds | input | 19 | Stack table length in entries |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| pa | output | 32 | Physical address (0 on fault) |
| fault | output | 3 | 0 ok, 1 segment, 2 bounds, 3 invalid, 4 not present |
| res_pte | output | 32 | Entry used for the translation |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Entry address |
| mem_ack | input | 1 | Read complete, data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The bench uses the default parameters: 32-bit virtual and physical addresses, 4 KB pages and 4-byte entries. The bounds are chosen so that the edges are reachable. The code table is 16 entries long, so both its last entry and the first entry past its end are tried. The heap table is empty, so every heap address faults. The stack table spans all 2^18 pages, so the highest virtual address is fetched at the top of its table. The acknowledge delay is varied between zero and two cycles to exercise the request hold.

// File: rtl/seg_pt_walker.sv
module seg_pt_walker #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PG_BITS   = 12,
  parameter int SEG_BITS  = 2,
  parameter int PTE_BYTES = 4,
  parameter int PTE_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [VA_W-1:0]                   va,
  input  logic [PA_W-1:0]                   code_base,
  input  logic [VA_W-SEG_BITS-PG_BITS:0]    code_bounds,
  input  logic [PA_W-1:0]                   heap_base,
  input  logic [VA_W-SEG_BITS-PG_BITS:0]    heap_bounds,
  input  logic [PA_W-1:0]                   stack_base,
  input  logic [VA_W-SEG_BITS-PG_BITS:0]    stack_bounds,
  output logic                              busy,
  output logic                              done,
  output logic [PA_W-1:0]                   pa,
  output logic [2:0]                        fault,
  output logic [PTE_W-1:0]                  res_pte,
  output logic                              mem_req,
  output logic [PA_W-1:0]                   mem_addr,
  input  logic                              mem_ack,
  input  logic [PTE_W-1:0]                  mem_rdata
);

  localparam int VPN_W  = VA_W - SEG_BITS - PG_BITS;
  localparam int BND_W  = VPN_W + 1;
  localparam int PFN_W  = PA_W - PG_BITS;
  localparam int PTE_SH = $clog2(PTE_BYTES);
  localparam int V_BIT  = 0;
  localparam int P_BIT  = 1;

  localparam logic [2:0] F_NONE = 3'd0;
  localparam logic [2:0] F_SEG  = 3'd1;
  localparam logic [2:0] F_BND  = 3'd2;
  localparam logic [2:0] F_INV  = 3'd3;
  localparam logic [2:0] F_NP   = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FETCH, S_DONE} st_t;
  st_t st;

  logic [VA_W-1:0]     va_q;
  logic [SEG_BITS-1:0] seg;
  logic [VPN_W-1:0]    vpn;
  logic                seg_ok;
  logic [PA_W-1:0]     sel_base;
  logic [BND_W-1:0]    sel_bnd;
  logic                in_bnd;
  logic [PA_W-1:0]     pte_off;

  assign seg     = va_q[VA_W-1 -: SEG_BITS];
  assign vpn     = va_q[PG_BITS +: VPN_W];
  assign pte_off = PA_W'(vpn) << PTE_SH;
  assign in_bnd  = {1'b0, vpn} < sel_bnd;

  always_comb begin
    seg_ok   = 1'b1;
    sel_base = code_base;
    sel_bnd  = code_bounds;
    case (seg)
      SEG_BITS'(1): begin sel_base = code_base;  sel_bnd = code_bounds;  end
      SEG_BITS'(2): begin sel_base = heap_base;  sel_bnd = heap_bounds;  end
      SEG_BITS'(3): begin sel_base = stack_base; sel_bnd = stack_bounds; end
      default:      seg_ok = 1'b0;
    endcase
  end

  assign busy    = st != S_IDLE;
  assign done    = st == S_DONE;
  assign mem_req = st == S_FETCH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      va_q     <= '0;
      mem_addr <= '0;
      pa       <= '0;
      fault    <= F_NONE;
      res_pte  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          va_q <= va;
          st   <= S_LOOK;
        end
        S_LOOK: begin
          if (!seg_ok || !in_bnd) begin
            fault   <= seg_ok ? F_BND : F_SEG;
            pa      <= '0;
            res_pte <= '0;
            st      <= S_DONE;
          end else begin
            mem_addr <= sel_base + pte_off;
            st       <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack) begin
          res_pte <= mem_rdata;
          if (!mem_rdata[V_BIT]) begin
            fault <= F_INV;
            pa    <= '0;
          end else if (!mem_rdata[P_BIT]) begin
            fault <= F_NP;
            pa    <= '0;
          end else begin
            fault <= F_NONE;
            pa    <= {mem_rdata[PTE_W-1 -: PFN_W], va_q[PG_BITS-1:0]};
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r5_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req && done);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  a_r3_fetch_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> seg_ok && in_bnd);

  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == F_NONE |-> pa[PG_BITS-1:0] == va_q[PG_BITS-1:0]);

  a_r6_fault_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fault <= F_NP);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !busy && !mem_req);

endmodule

// File: tb/seg_pt_walker_test.sv
module seg_pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] va = '0;
  logic [31:0] code_base = 32'h0010_0000, heap_base = 32'h0020_0000, stack_base = 32'h0030_0000;
  logic [18:0] code_bounds = 19'd16, heap_bounds = 19'd0, stack_bounds = 19'h40000;
  logic        busy, done, mem_req, mem_ack = 1'b0;
  logic [31:0] pa, res_pte, mem_addr, mem_rdata = '0;
  logic [2:0]  fault;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_pt_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va),
    .code_base(code_base), .code_bounds(code_bounds),
    .heap_base(heap_base), .heap_bounds(heap_bounds),
    .stack_base(stack_base), .stack_bounds(stack_bounds),
    .busy(busy), .done(done), .pa(pa), .fault(fault), .res_pte(res_pte),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pte;
    logic [31:0] addr;
    logic [31:0] pa;
    logic [2:0]  fault;
    logic        fetch;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'h4000_3ABC, 32'h1234_502B, 32'h0010_000C, 32'h1234_5ABC, 3'd0, 1'b1},
    '{32'h4000_F123, 32'h000A_B01F, 32'h0010_003C, 32'h000A_B123, 3'd0, 1'b1},
    '{32'h4001_0000, 32'h0,         32'h0,         32'h0,         3'd2, 1'b0},
    '{32'h0000_1000, 32'h0,         32'h0,         32'h0,         3'd1, 1'b0},
    '{32'h8000_0000, 32'h0,         32'h0,         32'h0,         3'd2, 1'b0},
    '{32'hFFFF_FFFF, 32'hFEDC_B01B, 32'h003F_FFFC, 32'hFEDC_BFFF, 3'd0, 1'b1},
    '{32'hC000_5010, 32'h1111_1002, 32'h0030_0014, 32'h0,         3'd3, 1'b1},
    '{32'hC000_6000, 32'h2222_2001, 32'h0030_0018, 32'h0,         3'd4, 1'b1},
    '{32'hC000_7000, 32'h0,         32'h0030_001C, 32'h0,         3'd3, 1'b1},
    '{32'h4000_0000, 32'h0000_103B, 32'h0010_0000, 32'h0000_1000, 3'd0, 1'b1}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input int delay);
    int acks = 0;
    int waitc = 0;
    int cyc = 0;
    logic stray = 1'b0;
    logic addr_ok = 1'b1;
    logic seen = 1'b0;
    va = v.va;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c < 60; c++) begin
      if (done) begin
        seen = 1'b1;
        cyc = c;
        break;
      end
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (!v.fetch || acks > 0) stray = 1'b1;
        if (mem_addr != v.addr) addr_ok = 1'b0;
        if (waitc >= delay) begin
          mem_rdata = v.pte;
          mem_ack = 1'b1;
          acks++;
        end else begin
          waitc++;
        end
      end
      @(negedge clk);
    end
    mem_ack = 1'b0;
    chk(seen, "R8 done seen", 32'(seen), 32'd1);
    chk(!stray, "R5 R2 R3 request count", 32'(acks), 32'(v.fetch));
    if (v.fetch) chk(addr_ok, "R4 entry address", mem_addr, v.addr);
    if (!v.fetch) chk(cyc == 2, "R8 fault latency", 32'(cyc), 32'd2);
    chk(fault == v.fault, "R2 R3 R6 R7 fault code", 32'(fault), 32'(v.fault));
    chk(pa == v.pa, "R7 physical address", pa, v.pa);
    chk(res_pte == v.pte, "R6 R7 entry out", res_pte, v.pte);
    @(negedge clk);
    chk(!done, "R8 single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 reset idle", {29'd0, busy, done, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 after release", {29'd0, busy, done, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) run(VEC[i], i % 3);

    // R9: second start during fetch is ignored
    va = VEC[0].va;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(mem_req, "R9 fetch reached", 32'(mem_req), 32'd1);
    va = VEC[5].va;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_addr == VEC[0].addr, "R9 address unchanged", mem_addr, VEC[0].addr);
    mem_rdata = VEC[0].pte;
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk(done && pa == VEC[0].pa, "R9 first result kept", pa, VEC[0].pa);
    begin
      logic extra = 1'b0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (busy || mem_req) extra = 1'b1;
      end
      chk(!extra, "R9 no queued walk", 32'(extra), 32'd0);
    end

    // R1: reset in the middle of a fetch
    va = VEC[5].va;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req && !done, "R1 reset mid walk", {29'd0, busy, done, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run(VEC[1], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule